// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Core

This block is the combinational core of a small field-configurable logic device. Twelve dedicated inputs and ten feedback signals are each expanded into a true line and an inverted line. A programmable AND plane forms product terms from any subset of these lines. Fixed OR gates then sum those terms into ten outputs.

The OR gates do not receive equal shares of terms. The two outermost outputs get the fewest terms and the two central outputs get the most. Beyond the summing terms there are further product terms: one per output serves as its output-enable condition, one serves as a global preset condition, and one serves as a global clear condition. The output registers, the tristate pins and the clocking are built around this core and are not part of it.

Configuration is one flat connection vector on a port, with one bit for each line/term crossing. The core has no clock. Every output settles combinationally from the inputs and the configuration, so no valid/ready handshake applies to it.

Top module: `pta_array`

## Requirements
- R1: The AND plane sees 44 lines. Line 2*i is dedicated input i and line 2*i+1 is its inverse (i = 0..11). Line 24+2*j is feedback j and line 25+2*j is its inverse (j = 0..9).
- R2: Configuration bit `fuse_map[t*44 + l]` = 1 connects line l to product term t. A product term is the AND of every line connected to it.
- R3: A product term whose 44 configuration bits are all 0 evaluates to 1, whatever the inputs are.
- R4: A product term connected to both the true line and the inverse line of the same signal evaluates to 0 and never raises its output.
- R5: Summing terms are numbered 0..119 and assigned to the outputs in order. Output k receives the next block of terms, with block sizes 8, 10, 12, 14, 16, 16, 14, 12, 10, 8 for k = 0..9. Output 0 therefore takes terms 0..7 and output 9 takes terms 112..119.
- R6: `sum_out[k]` is the OR of the product terms in block k and of no other term.
- R7: `oe_term[k]` is product term 120+k.
- R8: `clear_term` is product term 130 and `preset_term` is product term 131.
- R9: With an all-zero configuration, every `sum_out` bit, every `oe_term` bit, `preset_term` and `clear_term` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ded_in | input | 12 | Dedicated input signals |
| fb_in | input | 10 | Feedback signals from the I/O cells |
| fuse_map | input | 5808 | Connection bits, index term*44 + line |
| sum_out | output | 10 | OR sums, one per output |
| oe_term | output | 10 | Output-enable product terms |
| preset_term | output | 1 | Global preset product term |
| clear_term | output | 1 | Global clear product term |

## Verification
The bench places a single live term at the first and at the last position of each output's block, with every other term blocked. This exposes any off-by-one in the uneven allocation: a design that got it wrong would raise a neighbouring output or stay silent. A design that dropped the inverse lines would fail the contradiction and inverse-literal tests. A design that mishandled empty rows would report 0 instead of 1 for an erased array. Randomised sparse configurations, compared against a reference model, catch misrouted feedback lines and the wrong ordering of enable, preset and clear terms.

// File: rtl/pta_pkg.sv
package pta_pkg;
  // Number of summing terms given to output k (outer outputs smallest).
  function automatic int grp_size(input int k, input int n_out,
                                  input int min_sz, input int step);
    int pos;
    pos = (k < n_out / 2) ? k : (n_out - 1 - k);
    return min_sz + step * pos;
  endfunction

  // First summing-term index of output k; grp_base(n_out,...) is the total.
  function automatic int grp_base(input int k, input int n_out,
                                  input int min_sz, input int step);
    int acc;
    acc = 0;
    for (int i = 0; i < k; i++) acc += grp_size(i, n_out, min_sz, step);
    return acc;
  endfunction
endpackage

// File: rtl/pta_line_gen.sv
module pta_line_gen #(
  parameter int N_DED = 12,
  parameter int N_IO  = 10,
  localparam int N_LINES = 2 * (N_DED + N_IO)
) (
  input  logic [N_DED-1:0]   ded_in,
  input  logic [N_IO-1:0]    fb_in,
  output logic [N_LINES-1:0] lines
);
  for (genvar i = 0; i < N_DED; i++) begin : g_ded
    assign lines[2*i]   = ded_in[i];
    assign lines[2*i+1] = ~ded_in[i];
  end
  for (genvar j = 0; j < N_IO; j++) begin : g_fb
    assign lines[2*N_DED + 2*j]     = fb_in[j];
    assign lines[2*N_DED + 2*j + 1] = ~fb_in[j];
  end
endmodule

// File: rtl/pta_and_plane.sv
module pta_and_plane #(
  parameter int N_LINES = 44,
  parameter int N_TERMS = 132,
  localparam int CFG_W = N_LINES * N_TERMS
) (
  input  logic [N_LINES-1:0] lines,
  input  logic [CFG_W-1:0]   fuse_map,
  output logic [N_TERMS-1:0] terms
);
  // An open connection contributes a constant 1 to the AND.
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    assign terms[t] = &(lines | ~fuse_map[t*N_LINES +: N_LINES]);
  end
endmodule

// File: rtl/pta_or_plane.sv
module pta_or_plane #(
  parameter int N_IO     = 10,
  parameter int GRP_MIN  = 8,
  parameter int GRP_STEP = 2,
  localparam int N_SUM = pta_pkg::grp_base(N_IO, N_IO, GRP_MIN, GRP_STEP)
) (
  input  logic [N_SUM-1:0] sum_terms,
  output logic [N_IO-1:0]  sum_out
);
  for (genvar k = 0; k < N_IO; k++) begin : g_or
    localparam int BASE = pta_pkg::grp_base(k, N_IO, GRP_MIN, GRP_STEP);
    localparam int SIZE = pta_pkg::grp_size(k, N_IO, GRP_MIN, GRP_STEP);
    assign sum_out[k] = |sum_terms[BASE +: SIZE];
  end
endmodule

// File: rtl/pta_array.sv
module pta_array #(
  parameter int N_DED    = 12,
  parameter int N_IO     = 10,
  parameter int GRP_MIN  = 8,
  parameter int GRP_STEP = 2,
  localparam int N_LINES = 2 * (N_DED + N_IO),
  localparam int N_SUM   = pta_pkg::grp_base(N_IO, N_IO, GRP_MIN, GRP_STEP),
  localparam int N_TERMS = N_SUM + N_IO + 2,
  localparam int CFG_W   = N_TERMS * N_LINES
) (
  input  logic [N_DED-1:0] ded_in,
  input  logic [N_IO-1:0]  fb_in,
  input  logic [CFG_W-1:0] fuse_map,
  output logic [N_IO-1:0]  sum_out,
  output logic [N_IO-1:0]  oe_term,
  output logic             preset_term,
  output logic             clear_term
);
  logic [N_LINES-1:0] line_vec;
  logic [N_TERMS-1:0] term_vec;

  pta_line_gen #(.N_DED(N_DED), .N_IO(N_IO)) u_lines (
    .ded_in(ded_in), .fb_in(fb_in), .lines(line_vec)
  );

  pta_and_plane #(.N_LINES(N_LINES), .N_TERMS(N_TERMS)) u_and (
    .lines(line_vec), .fuse_map(fuse_map), .terms(term_vec)
  );

  pta_or_plane #(.N_IO(N_IO), .GRP_MIN(GRP_MIN), .GRP_STEP(GRP_STEP)) u_or (
    .sum_terms(term_vec[N_SUM-1:0]), .sum_out(sum_out)
  );

  // Special terms follow the summing terms: enables, then clear, then preset.
  assign oe_term     = term_vec[N_SUM +: N_IO];
  assign clear_term  = term_vec[N_SUM + N_IO];
  assign preset_term = term_vec[N_SUM + N_IO + 1];
endmodule

// File: rtl/pta_array_chk.sv
module pta_array_chk #(
  parameter int N_DED    = 12,
  parameter int N_IO     = 10,
  parameter int GRP_MIN  = 8,
  parameter int GRP_STEP = 2,
  localparam int N_LINES = 2 * (N_DED + N_IO),
  localparam int N_SUM   = pta_pkg::grp_base(N_IO, N_IO, GRP_MIN, GRP_STEP),
  localparam int N_TERMS = N_SUM + N_IO + 2,
  localparam int CFG_W   = N_TERMS * N_LINES
) (
  input logic [CFG_W-1:0]   fuse_map,
  input logic [N_TERMS-1:0] term_vec,
  input logic [N_IO-1:0]    sum_out,
  input logic [N_IO-1:0]    oe_term,
  input logic               preset_term,
  input logic               clear_term
);
  always_comb begin
    for (int t = 0; t < N_TERMS; t++) begin
      if (fuse_map[t*N_LINES +: N_LINES] == '0)
        AST_EMPTY_TERM_TRUE: assert (term_vec[t]) else $error("empty term low"); // R3
      for (int p = 0; p < N_LINES / 2; p++) begin
        if (fuse_map[t*N_LINES + 2*p] && fuse_map[t*N_LINES + 2*p + 1])
          AST_CONTRA_TERM_FALSE: assert (!term_vec[t]) else $error("contradiction high"); // R4
      end
    end
    for (int k = 0; k < N_IO; k++) begin
      if (term_vec[pta_pkg::grp_base(k, N_IO, GRP_MIN, GRP_STEP)])
        AST_GROUP_HEAD_RAISES_SUM: assert (sum_out[k]) else $error("sum missed term"); // R6
      if (term_vec[pta_pkg::grp_base(k + 1, N_IO, GRP_MIN, GRP_STEP) - 1])
        AST_GROUP_TAIL_RAISES_SUM: assert (sum_out[k]) else $error("sum missed tail"); // R5
    end
    if (fuse_map == '0)
      AST_ERASED_ALL_HIGH: assert (&sum_out && &oe_term && preset_term && clear_term)
        else $error("erased map not all high"); // R9
  end
endmodule

bind pta_array pta_array_chk #(
  .N_DED(N_DED), .N_IO(N_IO), .GRP_MIN(GRP_MIN), .GRP_STEP(GRP_STEP)
) u_chk (
  .fuse_map(fuse_map), .term_vec(term_vec), .sum_out(sum_out),
  .oe_term(oe_term), .preset_term(preset_term), .clear_term(clear_term)
);

// File: tb/pta_array_tb.sv
`timescale 1ns/1ps
module pta_array_tb;
  localparam int NL = 44;
  localparam int NT = 132;
  localparam int CW = NL * NT;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [11:0]   ded_in;
  logic [9:0]    fb_in;
  logic [CW-1:0] cfg;
  logic [9:0]    sum_out, oe_term;
  logic          preset_term, clear_term;

  int checks = 0;
  int errors = 0;

  pta_array u_dut (
    .ded_in(ded_in), .fb_in(fb_in), .fuse_map(cfg), .sum_out(sum_out),
    .oe_term(oe_term), .preset_term(preset_term), .clear_term(clear_term)
  );

  function automatic int gsz(input int k);
    return (k < 5) ? 8 + 2*k : 8 + 2*(9 - k);
  endfunction
  function automatic int gbase(input int k);
    int a = 0;
    for (int i = 0; i < k; i++) a += gsz(i);
    return a;
  endfunction

  // Reference model built from the requirements.
  function automatic logic ref_term(input int t);
    logic [NL-1:0] ln;
    for (int i = 0; i < 12; i++) begin ln[2*i] = ded_in[i]; ln[2*i+1] = ~ded_in[i]; end
    for (int j = 0; j < 10; j++) begin ln[24+2*j] = fb_in[j]; ln[25+2*j] = ~fb_in[j]; end
    for (int l = 0; l < NL; l++) if (cfg[t*NL + l] && !ln[l]) return 1'b0;
    return 1'b1;
  endfunction
  function automatic logic [9:0] ref_sum();
    logic [9:0] s = '0;
    for (int k = 0; k < 10; k++)
      for (int t = gbase(k); t < gbase(k) + gsz(k); t++) s[k] |= ref_term(t);
    return s;
  endfunction

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [11:0] d, input logic [9:0] f);
    @(posedge clk); #1;
    ded_in = d; fb_in = f;
    @(negedge clk);
  endtask

  task automatic block_all();
    cfg = '0;
    for (int t = 0; t < NT; t++) begin cfg[t*NL] = 1'b1; cfg[t*NL+1] = 1'b1; end
  endtask

  task automatic set_single(input int t, input int l);
    for (int i = 0; i < NL; i++) cfg[t*NL + i] = 1'b0;
    cfg[t*NL + l] = 1'b1;
  endtask

  task automatic t_erased();
    cfg = '0;
    apply(12'h5A3, 10'h2C1);
    check(sum_out, 10'h3FF, "R9 sums");
    check(oe_term, 10'h3FF, "R9 enables");
    check({preset_term, clear_term}, 2'b11, "R9 preset/clear");
    apply(12'h000, 10'h000);
    check(sum_out, 10'h3FF, "R3 empty terms true at zero inputs");
  endtask

  task automatic t_groups();
    for (int k = 0; k < 10; k++) begin
      for (int e = 0; e < 2; e++) begin
        block_all();
        set_single(e ? gbase(k) + gsz(k) - 1 : gbase(k), 0);
        apply(12'h001, 10'h000);
        check(sum_out, 10'h001 << k, "R5 group edge active");
        apply(12'h000, 10'h000);
        check(sum_out, 10'h000, "R6 group edge inactive");
      end
    end
  endtask

  task automatic t_contradiction();
    block_all();
    for (int p = 0; p < 22; p++) apply(12'(p * 37), 10'(p * 53));
    check(sum_out, 10'h000, "R4 blocked terms");
    check({oe_term, preset_term, clear_term}, 12'h000, "R4 blocked specials");
  endtask

  task automatic t_lines();
    // inverse of dedicated input 11 on output 3; feedback 9 true and inverse on output 7
    block_all();
    set_single(gbase(3), 23);
    set_single(gbase(7) + 1, 42);
    apply(12'h000, 10'h200);
    check(sum_out, 10'h088, "R1 inverse dedicated and true feedback");
    apply(12'h800, 10'h000);
    check(sum_out, 10'h000, "R1 both lines low");
    set_single(gbase(7) + 1, 43);
    apply(12'h000, 10'h000);
    check(sum_out, 10'h088, "R1 inverse feedback");
  endtask

  task automatic t_and();
    block_all();
    set_single(gbase(5), 4);
    cfg[gbase(5)*NL + 30] = 1'b1;
    apply(12'h004, 10'h008);
    check(sum_out, 10'h020, "R2 both literals true");
    apply(12'h004, 10'h000);
    check(sum_out, 10'h000, "R2 one literal false");
  endtask

  task automatic t_specials();
    block_all();
    for (int k = 0; k < 10; k++) begin
      block_all();
      set_single(120 + k, 2*k);
      apply(12'hFFF, 10'h000);
      check(oe_term, 10'h001 << k, "R7 enable term position");
      check(sum_out, 10'h000, "R7 enable not summed");
    end
    block_all();
    set_single(130, 6);
    set_single(131, 7);
    apply(12'h008, 10'h000);
    check({preset_term, clear_term}, 2'b01, "R8 clear term");
    apply(12'h000, 10'h000);
    check({preset_term, clear_term}, 2'b10, "R8 preset term");
  endtask

  task automatic t_random();
    void'($urandom(32'd7));
    for (int n = 0; n < 40; n++) begin
      cfg = '0;
      for (int t = 0; t < NT; t++)
        for (int c = 0; c < 3; c++) cfg[t*NL + ($urandom % NL)] = 1'b1;
      apply(12'($urandom), 10'($urandom));
      check(sum_out, ref_sum(), "R6 random sums");
      for (int k = 0; k < 10; k++) check(oe_term[k], ref_term(120 + k), "R7 random enable");
      check({preset_term, clear_term}, {ref_term(131), ref_term(130)}, "R8 random specials");
    end
  endtask

  initial begin
    ded_in = '0; fb_in = '0; cfg = '0;
    t_erased();
    t_groups();
    t_contradiction();
    t_lines();
    t_and();
    t_specials();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule